// File: doc/BRIEF.md
# RV32I Instruction Decoder and Immediate Generator

This block splits a 32-bit base-integer instruction word into the pieces the rest of a single-cycle datapath needs. It names the encoding format through six one-hot flags, brings out the three register indices and the function and opcode fields, and rebuilds the format's immediate as one sign-extended operand.

The unit holds no state. Every output follows the instruction input within the same cycle, so it sits between the fetch path and the register file and execute logic. An opcode outside the recognised set raises no flag and yields a zero immediate. Multiply and divide, compressed forms, system and privileged encodings, and control-signal generation are handled elsewhere. The instruction word is plain data with no handshake because the unit cannot stall. The immediate width is a parameter of 32 or more. Above bit 31, the upper bits copy the immediate's sign.

Top module: `rv_inst_decode`

## Requirements
- R1: `opc` equals instr[6:0], `fn3` equals instr[14:12] and `fn7` equals instr[31:25] for every input word.
- R2: `src1_idx` is instr[19:15], `src2_idx` is instr[24:20] and `dst_idx` is instr[11:7], whatever the opcode.
- R3: Opcode 0x33 raises `is_r`. Opcodes 0x13, 0x03 and 0x67 raise `is_i`. 0x23 raises `is_s` and 0x63 raises `is_b`. 0x17 and 0x37 raise `is_u`, and 0x6F raises `is_j`. At most one flag is high, and any other opcode raises none.
- R4: For an I-format word, `imm_val` is instr[31:20] sign-extended.
- R5: For an S-format word, `imm_val` is {instr[31:25], instr[11:7]} sign-extended from its bit 11.
- R6: For a B-format word, `imm_val` is sign-extended from bit 12. Its bits are: [12]=instr[31], [11]=instr[7], [10:5]=instr[30:25], [4:1]=instr[11:8] and [0]=0.
- R7: For a U-format word, `imm_val` is instr[31:12] above twelve zero bits.
- R8: For a J-format word, `imm_val` is sign-extended from bit 20. Its bits are: [20]=instr[31], [19:12]=instr[19:12], [11]=instr[20], [10:1]=instr[30:21] and [0]=0.
- R9: `imm_val` is zero for an R-format word and for an unrecognised opcode.
- R10: When any of the I, S, B, U or J flags is high, the top bit of `imm_val` equals instr[31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| is_r | output | 1 | Register-register format |
| is_i | output | 1 | Immediate, load or indirect-jump format |
| is_s | output | 1 | Store format |
| is_b | output | 1 | Conditional-branch format |
| is_u | output | 1 | Upper-immediate format |
| is_j | output | 1 | Direct-jump format |
| src1_idx | output | 5 | First source register index |
| src2_idx | output | 5 | Second source register index |
| dst_idx | output | 5 | Destination register index |
| fn3 | output | 3 | Three-bit function field |
| fn7 | output | 7 | Seven-bit function field |
| opc | output | 7 | Opcode field |
| imm_val | output | XLEN | Reassembled sign-extended immediate |

## Verification
Every result is due in the same cycle as its instruction word, with no register on the way. The bench changes the word just after a rising edge and reads all outputs at the following falling edge, which leaves half a period for the logic to settle. Expected fields, flags and immediates come from bench functions written directly from the bit positions in the requirements. These functions are applied to directed corner words and to fixed-seed random words, and half of the random words are forced onto valid opcodes.

// File: rtl/rv_dec_pkg.sv
package rv_dec_pkg;
  localparam int ILEN   = 32;
  localparam int OPC_W  = 7;
  localparam int REG_AW = 5;
  localparam int F3_W   = 3;
  localparam int F7_W   = 7;

  localparam logic [OPC_W-1:0] OPC_REG    = 7'h33;
  localparam logic [OPC_W-1:0] OPC_ARITHI = 7'h13;
  localparam logic [OPC_W-1:0] OPC_LOAD   = 7'h03;
  localparam logic [OPC_W-1:0] OPC_JREG   = 7'h67;
  localparam logic [OPC_W-1:0] OPC_STORE  = 7'h23;
  localparam logic [OPC_W-1:0] OPC_BRANCH = 7'h63;
  localparam logic [OPC_W-1:0] OPC_AUPC   = 7'h17;
  localparam logic [OPC_W-1:0] OPC_UPPER  = 7'h37;
  localparam logic [OPC_W-1:0] OPC_JUMP   = 7'h6F;

  typedef enum logic [2:0] {
    FMT_NONE = 3'd0,
    FMT_R    = 3'd1,
    FMT_I    = 3'd2,
    FMT_S    = 3'd3,
    FMT_B    = 3'd4,
    FMT_U    = 3'd5,
    FMT_J    = 3'd6
  } fmt_e;
endpackage

// File: rtl/rv_dec_classify.sv
module rv_dec_classify
  import rv_dec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output fmt_e             fmt
);
  always_comb begin
    case (opcode)
      OPC_REG:                          fmt = FMT_R;
      OPC_ARITHI, OPC_LOAD, OPC_JREG:   fmt = FMT_I;
      OPC_STORE:                        fmt = FMT_S;
      OPC_BRANCH:                       fmt = FMT_B;
      OPC_AUPC, OPC_UPPER:              fmt = FMT_U;
      OPC_JUMP:                         fmt = FMT_J;
      default:                          fmt = FMT_NONE;
    endcase
  end
endmodule

// File: rtl/rv_dec_fields.sv
module rv_dec_fields
  import rv_dec_pkg::*;
(
  input  logic [ILEN-1:0]   word,
  output logic [REG_AW-1:0] rs1,
  output logic [REG_AW-1:0] rs2,
  output logic [REG_AW-1:0] rd,
  output logic [F3_W-1:0]   f3,
  output logic [F7_W-1:0]   f7,
  output logic [OPC_W-1:0]  op
);
  assign op  = word[OPC_W-1:0];
  assign rd  = word[11:7];
  assign f3  = word[14:12];
  assign rs1 = word[19:15];
  assign rs2 = word[24:20];
  assign f7  = word[31:25];
endmodule

// File: rtl/rv_dec_immgen.sv
module rv_dec_immgen
  import rv_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [ILEN-1:7] bits,
  input  fmt_e            fmt,
  output logic [XLEN-1:0] imm
);
  logic [ILEN-1:0] raw;
  logic            sgn;

  assign sgn = bits[31];

  always_comb begin
    case (fmt)
      FMT_I:   raw = {{20{sgn}}, bits[31:20]};
      FMT_S:   raw = {{20{sgn}}, bits[31:25], bits[11:7]};
      FMT_B:   raw = {{19{sgn}}, sgn, bits[7], bits[30:25], bits[11:8], 1'b0};
      FMT_U:   raw = {bits[31:12], 12'b0};
      FMT_J:   raw = {{11{sgn}}, sgn, bits[19:12], bits[20], bits[30:21], 1'b0};
      default: raw = '0;
    endcase
  end

  generate
    if (XLEN > ILEN) begin : g_wide
      assign imm = {{(XLEN-ILEN){raw[ILEN-1]}}, raw};
    end else begin : g_native
      assign imm = raw[XLEN-1:0];
    end
  endgenerate
endmodule

// File: rtl/rv_inst_decode.sv
module rv_inst_decode
  import rv_dec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr,
  output logic            is_r,
  output logic            is_i,
  output logic            is_s,
  output logic            is_b,
  output logic            is_u,
  output logic            is_j,
  output logic [4:0]      src1_idx,
  output logic [4:0]      src2_idx,
  output logic [4:0]      dst_idx,
  output logic [2:0]      fn3,
  output logic [6:0]      fn7,
  output logic [6:0]      opc,
  output logic [XLEN-1:0] imm_val
);
  fmt_e fmt;

  rv_dec_fields u_fields (
    .word (instr),
    .rs1  (src1_idx),
    .rs2  (src2_idx),
    .rd   (dst_idx),
    .f3   (fn3),
    .f7   (fn7),
    .op   (opc)
  );

  rv_dec_classify u_class (
    .opcode (instr[OPC_W-1:0]),
    .fmt    (fmt)
  );

  rv_dec_immgen #(.XLEN(XLEN)) u_imm (
    .bits (instr[ILEN-1:7]),
    .fmt  (fmt),
    .imm  (imm_val)
  );

  assign is_r = (fmt == FMT_R);
  assign is_i = (fmt == FMT_I);
  assign is_s = (fmt == FMT_S);
  assign is_b = (fmt == FMT_B);
  assign is_u = (fmt == FMT_U);
  assign is_j = (fmt == FMT_J);
endmodule

// File: rtl/rv_inst_decode_chk.sv
module rv_inst_decode_chk #(
  parameter int XLEN = 32
) (
  input logic [31:0]     instr,
  input logic            is_r,
  input logic            is_i,
  input logic            is_s,
  input logic            is_b,
  input logic            is_u,
  input logic            is_j,
  input logic [4:0]      src1_idx,
  input logic [4:0]      src2_idx,
  input logic [4:0]      dst_idx,
  input logic [2:0]      fn3,
  input logic [6:0]      fn7,
  input logic [6:0]      opc,
  input logic [XLEN-1:0] imm_val
);
  logic [5:0] flags;
  logic       any_imm;
  assign flags   = {is_r, is_i, is_s, is_b, is_u, is_j};
  assign any_imm = is_i | is_s | is_b | is_u | is_j;

  always_comb begin
    if (!$isunknown(instr)) begin
      p_onehot_flags_r3: assert ($onehot0(flags))
        else $error("flags not one-hot: %b", flags);
      p_fields_r1: assert (opc == instr[6:0] && fn3 == instr[14:12] && fn7 == instr[31:25])
        else $error("field extraction mismatch");
      p_regidx_r2: assert (src1_idx == instr[19:15] && src2_idx == instr[24:20] && dst_idx == instr[11:7])
        else $error("register index mismatch");
      p_zero_imm_r9: assert (any_imm || imm_val == '0)
        else $error("immediate not zero without format");
      p_sign_r10: assert (!any_imm || imm_val[XLEN-1] == instr[31])
        else $error("immediate sign bit wrong");
      p_b_even_r6: assert (!is_b || imm_val[0] == 1'b0)
        else $error("branch offset odd");
      p_j_even_r8: assert (!is_j || imm_val[0] == 1'b0)
        else $error("jump offset odd");
      p_u_low_r7: assert (!is_u || imm_val[11:0] == 12'h000)
        else $error("upper immediate low bits set");
    end
  end
endmodule

bind rv_inst_decode rv_inst_decode_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_rv_inst_decode.sv
`timescale 1ns/1ps
module sim_rv_inst_decode;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr;
  logic        is_r, is_i, is_s, is_b, is_u, is_j;
  logic [4:0]  src1_idx, src2_idx, dst_idx;
  logic [2:0]  fn3;
  logic [6:0]  fn7, opc;
  logic [31:0] imm_val;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  rv_inst_decode #(.XLEN(32)) u0 (.*);

  function automatic logic [5:0] exp_flags(input logic [31:0] w);
    case (w[6:0])
      7'h33:               return 6'b100000;
      7'h13, 7'h03, 7'h67: return 6'b010000;
      7'h23:               return 6'b001000;
      7'h63:               return 6'b000100;
      7'h17, 7'h37:        return 6'b000010;
      7'h6F:               return 6'b000001;
      default:             return 6'b000000;
    endcase
  endfunction

  function automatic logic [31:0] exp_imm(input logic [31:0] w);
    logic [5:0] f;
    f = exp_flags(w);
    if (f[4]) return {{20{w[31]}}, w[31:20]};
    if (f[3]) return {{20{w[31]}}, w[31:25], w[11:7]};
    if (f[2]) return {{20{w[31]}}, w[7], w[30:25], w[11:8], 1'b0};
    if (f[1]) return {w[31:12], 12'h000};
    if (f[0]) return {{12{w[31]}}, w[19:12], w[20], w[30:21], 1'b0};
    return 32'h0;
  endfunction

  function automatic string imm_tag(input logic [31:0] w);
    logic [5:0] f;
    f = exp_flags(w);
    if (f[4]) return "R4";
    if (f[3]) return "R5";
    if (f[2]) return "R6";
    if (f[1]) return "R7";
    if (f[0]) return "R8";
    return "R9";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp,
                       input logic [31:0] w);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s instr=%08h actual=%0h expected=%0h", tag, w, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    logic [31:0] ei;
    @(posedge clk);
    #1 instr = w;
    @(negedge clk);
    check("R1", {43'd0, opc, fn3, fn7}, {43'd0, w[6:0], w[14:12], w[31:25]}, w);
    check("R2", {49'd0, src1_idx, src2_idx, dst_idx}, {49'd0, w[19:15], w[24:20], w[11:7]}, w);
    check("R3", {58'd0, is_r, is_i, is_s, is_b, is_u, is_j}, {58'd0, exp_flags(w)}, w);
    ei = exp_imm(w);
    check(imm_tag(w), {32'd0, imm_val}, {32'd0, ei}, w);
    if (exp_flags(w) inside {6'b010000, 6'b001000, 6'b000100, 6'b000010, 6'b000001})
      check("R10", {63'd0, imm_val[31]}, {63'd0, w[31]}, w);
  endtask

  localparam logic [6:0] OPS [9] = '{7'h33, 7'h13, 7'h03, 7'h67, 7'h23,
                                     7'h63, 7'h17, 7'h37, 7'h6F};

  initial begin
    logic [31:0] w;
    instr = 32'h0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: zero word, unknown opcode -> no flag, zero immediate (R3, R9)
    apply(32'h0000_0000);
    // directed corners per opcode with all-ones and sign-only payloads
    for (int k = 0; k < 9; k++) begin
      apply({25'h1FF_FFFF, OPS[k]});
      apply({25'h100_0000, OPS[k]});
      apply({25'h0AA_5555, OPS[k]});
    end
    // unrecognised opcodes: system, custom, all-ones (R3, R9)
    apply(32'hFFFF_FF73);
    apply(32'hFFFF_FFFF);
    apply(32'h8000_000B);
    // random traffic, fixed seed
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      w = $urandom();
      if (n[0]) w[6:0] = OPS[$urandom_range(0, 8)];
      apply(w);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule